// File: doc/BRIEF.md
# Gated Fractional PWM Prescaler

This block generates the count-enable pulses that advance a PWM counter. A fixed-point divisor with an 8-bit whole part and a 4-bit fraction sets how many qualifying events make up one output tick. Fractional divisors spread the ticks so that the long-run tick rate equals the event rate divided by the divisor.

A two-bit mode input selects the event source. In free-running mode every enabled clock cycle is an event, so the block acts as a clock prescaler. In the other three modes the block counts activity on an external input pin: cycles where the pin is high, rising edges, or falling edges. The pin is synchronised inside the block before it is used. The output is a plain single-cycle control pulse with no handshake. The PWM counter that consumes the pulse sits outside this block and never back-pressures it.

Internally a phase accumulator holds progress in sixteenths. Each event adds one whole unit (16). When the total reaches the divisor, the block emits a tick and subtracts the divisor.

Top module: `pwm_event_prescaler`

## Requirements
- R1: After reset the tick output is low and the accumulator is empty. With an integer divisor N, the first tick follows the N-th event.
- R2: The mode codes are as follows. 0 counts every enabled clock cycle. 1 counts cycles where the synchronised pin is high. 2 counts synchronised rising edges. 3 counts synchronised falling edges.
- R3: In mode 0 with an integer divisor N and enable held high, exactly one tick is produced every N cycles.
- R4: A fractional divisor produces ticks whose count over a whole number of periods equals events divided by divisor. Examples: 1.5 gives 20 ticks per 30 events, and 2.25 gives 16 ticks per 36 events.
- R5: A divisor whose integer field is 0 is treated as 1.0, so every event produces a tick.
- R6: In mode 1 a pin held high for H cycles yields H events. A pin held low yields none.
- R7: In mode 2 each low-to-high pin transition is one event. A pin held high adds no further events.
- R8: In mode 3 each high-to-low pin transition is one event. A rise, or a pin held high, adds none.
- R9: The pin passes through two synchronising flops. With divisor 1.0 in mode 2, a pin rise set up before clock edge 1 gives a tick that is high after edge 3 only.
- R10: While enable is low no tick is produced and the accumulator keeps its value. Counting resumes from that value when enable returns high.
- R11: A tick is high only in the cycle after an enabled qualifying event, and each event produces at most one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows events to be counted |
| mode | input | 2 | Event source select (R2 codes) |
| div_int | input | INT_W (8) | Whole part of the divisor |
| div_frac | input | FRAC_W (4) | Fractional part of the divisor, in sixteenths |
| pin_in | input | 1 | Raw asynchronous external input |
| tick | output | 1 | Single-cycle count-enable pulse |

## Verification
The bench builds the block with its default widths: an 8-bit whole part, a 4-bit fraction and two synchroniser stages. With these widths the fractional spreading at steps of one sixteenth can be reached, including the 1.5 and 2.25 patterns. So can the zero-integer clamp and the exact three-edge pin-to-tick latency. The pin-driven modes are run with pulse trains and long held levels, so that the level, rise and fall sources each give counts that differ from the other two.

// File: rtl/pwm_prescaler_pkg.sv
package pwm_prescaler_pkg;

  typedef enum logic [1:0] {
    SRC_ALWAYS  = 2'd0,
    SRC_LEVEL   = 2'd1,
    SRC_RISE    = 2'd2,
    SRC_FALL    = 2'd3
  } evt_src_e;

endpackage

// File: rtl/pin_synchroniser.sv
module pin_synchroniser #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic level_prev
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("pin_synchroniser needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '0;
      prev_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], raw};
      prev_q <= chain[STAGES-1];
    end
  end

  assign level      = chain[STAGES-1];
  assign level_prev = prev_q;

endmodule

// File: rtl/event_qualifier.sv
module event_qualifier
  import pwm_prescaler_pkg::*;
(
  input  logic     enable,
  input  evt_src_e src,
  input  logic     level,
  input  logic     level_prev,
  output logic     evt
);

  logic qual;

  always_comb begin
    case (src)
      SRC_ALWAYS: qual = 1'b1;
      SRC_LEVEL:  qual = level;
      SRC_RISE:   qual = level & ~level_prev;
      SRC_FALL:   qual = ~level & level_prev;
      default:    qual = 1'b0;
    endcase
  end

  assign evt = enable & qual;

endmodule

// File: rtl/frac_accumulator.sv
module frac_accumulator #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);

  localparam int DIV_W = INT_W + FRAC_W;
  localparam int ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] ONE_STEP = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] div_eff;
  logic [ACC_W-1:0] sum;
  logic             reach;

  always_comb begin
    if (div_int == '0) div_eff = ONE_STEP;
    else               div_eff = {1'b0, div_int, div_frac};
  end

  assign sum   = acc_q + ONE_STEP;
  assign reach = (sum >= div_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= evt & reach;
      if (evt) acc_q <= reach ? (sum - div_eff) : sum;
    end
  end

endmodule

// File: rtl/pwm_event_prescaler.sv
module pwm_event_prescaler
  import pwm_prescaler_pkg::*;
#(
  parameter int INT_W       = 8,
  parameter int FRAC_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              pin_in,
  output logic              tick
);

  logic pin_sync;
  logic pin_prev;
  logic evt;

  pin_synchroniser #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw        (pin_in),
    .level      (pin_sync),
    .level_prev (pin_prev)
  );

  event_qualifier u_qual (
    .enable     (enable),
    .src        (evt_src_e'(mode)),
    .level      (pin_sync),
    .level_prev (pin_prev),
    .evt        (evt)
  );

  frac_accumulator #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .div_int  (div_int),
    .div_frac (div_frac),
    .tick     (tick)
  );

endmodule

// File: rtl/pwm_event_prescaler_checker.sv
module pwm_event_prescaler_checker #(
  parameter int INT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [1:0]       mode,
  input logic [INT_W-1:0] div_int,
  input logic             evt,
  input logic             sync_lvl,
  input logic             tick
);

  assert_quiet_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick);

  assert_tick_needs_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> !tick);

  assert_unit_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mode == 2'd0 && div_int == '0) |=> tick);

  assert_level_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && evt) |-> sync_lvl);

  assert_rise_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && evt) |-> $rose(sync_lvl));

  assert_fall_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && evt) |-> $fell(sync_lvl));

endmodule

bind pwm_event_prescaler pwm_event_prescaler_checker #(.INT_W(INT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .mode     (mode),
  .div_int  (div_int),
  .evt      (evt),
  .sync_lvl (pin_sync),
  .tick     (tick)
);

// File: tb/pwm_event_prescaler_test.sv
`timescale 1ns/1ps
module pwm_event_prescaler_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [1:0] mode;
  logic [7:0] div_int;
  logic [3:0] div_frac;
  logic       pin_in;
  logic       tick;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwm_event_prescaler uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .mode     (mode),
    .div_int  (div_int),
    .div_frac (div_frac),
    .pin_in   (pin_in),
    .tick     (tick)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b0; mode = 2'd0;
    div_int = 8'd1; div_frac = 4'd0; pin_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (tick) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
  endtask

  task automatic test_reset();
    int c, f;
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b1; mode = 2'd0; div_int = 8'd1; div_frac = 4'd0; pin_in = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R1 tick low in reset", int'(tick), 0);
    enable = 1'b0;
    rst_n = 1'b1;
    run(5, c, f);
    check_eq("R1 idle after reset", c, 0);
  endtask

  task automatic test_free_integer();
    int c, f;
    do_reset();
    mode = 2'd0; div_int = 8'd3; enable = 1'b1;
    run(30, c, f);
    check_eq("R3 div 3 count", c, 10);
    check_eq("R1 first tick at event 3", f, 3);
    do_reset();
    mode = 2'd0; div_int = 8'd1; enable = 1'b1;
    run(12, c, f);
    check_eq("R3 div 1 count", c, 12);
  endtask

  task automatic test_fraction();
    int c, f;
    do_reset();
    mode = 2'd0; div_int = 8'd1; div_frac = 4'd8; enable = 1'b1;
    run(30, c, f);
    check_eq("R4 div 1.5", c, 20);
    do_reset();
    mode = 2'd0; div_int = 8'd2; div_frac = 4'd4; enable = 1'b1;
    run(36, c, f);
    check_eq("R4 div 2.25", c, 16);
  endtask

  task automatic test_zero_int();
    int c, f;
    do_reset();
    mode = 2'd0; div_int = 8'd0; div_frac = 4'd8; enable = 1'b1;
    run(20, c, f);
    check_eq("R5 int 0 frac 8", c, 20);
    do_reset();
    mode = 2'd0; div_int = 8'd0; div_frac = 4'd0; enable = 1'b1;
    run(20, c, f);
    check_eq("R5 int 0 frac 0", c, 20);
  endtask

  task automatic test_disable();
    int c, f;
    do_reset();
    mode = 2'd0; div_int = 8'd4; enable = 1'b1;
    run(2, c, f);
    check_eq("R10 no tick before disable", c, 0);
    enable = 1'b0;
    run(10, c, f);
    check_eq("R10 no tick while disabled", c, 0);
    enable = 1'b1;
    run(2, c, f);
    check_eq("R10 resume from held state", f, 2);
  endtask

  task automatic test_level();
    int c1, c2, f;
    do_reset();
    mode = 2'd1; div_int = 8'd2; enable = 1'b1; pin_in = 1'b1;
    run(10, c1, f);
    pin_in = 1'b0;
    run(10, c2, f);
    check_eq("R6 level high 10 cycles div 2", c1 + c2, 5);
    run(20, c1, f);
    check_eq("R2 mode 1 pin low silent", c1, 0);
  endtask

  task automatic test_rise();
    int c, t, f;
    do_reset();
    mode = 2'd2; div_int = 8'd1; enable = 1'b1;
    t = 0;
    for (int p = 0; p < 5; p++) begin
      pin_in = 1'b1; run(3, c, f); t += c;
      pin_in = 1'b0; run(3, c, f); t += c;
    end
    check_eq("R7 five rising edges", t, 5);
    pin_in = 1'b1;
    run(12, c, f);
    check_eq("R7 held high one event", c, 1);
  endtask

  task automatic test_fall();
    int c, f;
    do_reset();
    mode = 2'd3; div_int = 8'd1; enable = 1'b1; pin_in = 1'b1;
    run(12, c, f);
    check_eq("R8 rise and hold ignored", c, 0);
    pin_in = 1'b0;
    run(6, c, f);
    check_eq("R8 one falling edge", c, 1);
  endtask

  task automatic test_latency();
    int c, f;
    do_reset();
    mode = 2'd2; div_int = 8'd1; enable = 1'b1;
    run(2, c, f);
    pin_in = 1'b1;
    run(5, c, f);
    check_eq("R9 tick after third edge", f, 3);
    check_eq("R9 single tick", c, 1);
  endtask

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; mode = 2'd0;
    div_int = 8'd1; div_frac = 4'd0; pin_in = 1'b0;
    test_reset();
    test_free_integer();
    test_fraction();
    test_zero_int();
    test_disable();
    test_level();
    test_rise();
    test_fall();
    test_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule